// File: doc/BRIEF.md
# Frequency-Offset Lock Detector

This block decides whether a recovered high-rate clock runs close enough to a local reference clock to call the loop locked. The recovered clock is divided by a fixed ratio so that, when on frequency, the divided rate equals the reference rate. A measurement window is timed by a reference-clock counter. The number of divided-clock periods seen during each window is compared with the window length, and the block declares lock when the two agree within a fixed tolerance. With the defaults (ratio 20, window 1024, tolerance 16 counts) the threshold is about 1.56 %, just under a 1.6 % fractional offset.

Counting runs in the recovered-clock domain. A window-boundary toggle travels into that domain through a synchronizer. The captured count goes back under a toggle acknowledge, so the multi-bit result is sampled only after it has settled. The flag is a register in the reference domain and changes only when a window result arrives or when a fault clears it. An active-low lock-to-reference input forces the flag low. After that input is released, or after reset, the flag stays low until one complete window has been measured entirely after the event.

Top module: `freq_lock_detect`

## Requirements
- R1: The recovered clock is divided by DIV_RATIO (default 20). One count stands for DIV_RATIO recovered-clock cycles, and the count rises by at most one per recovered-clock cycle. A recovered period of exactly DIV_RATIO times smaller than the reference period locks.
- R2: At the end of a valid window, lock_o is 1 when |count - WIN_CYCLES| <= TOL_COUNTS. With the defaults this holds for recovered periods of 197 ps to 203 ps against a 4 ns reference.
- R3: At the end of a valid window, lock_o is 0 when |count - WIN_CYCLES| > TOL_COUNTS. Examples are recovered periods of 196 ps, 204 ps, 180 ps and 230 ps.
- R4: The window counter saturates at 2^(clog2(WIN_CYCLES)+2)-1 (4095 by default) and does not wrap. A clock five times too fast, whose wrapped count would land on the nominal 1024, reports unlocked.
- R5: While lock_ref_n is 0, lock_o goes to 0 no later than three reference cycles after lock_ref_n falls, and it stays 0.
- R6: lock_o is 0 during reset. After reset it stays 0 through the first window boundary, because the first result is discarded. It can be 1 only after the second window completes.
- R7: After lock_ref_n returns to 1, lock_o stays 0 for at least 1000 reference cycles. It can rise only once a window that started after the release has completed.
- R8: Each window is judged anew. The flag falls when the frequency drifts out of tolerance and rises again when it returns.
- R9: lock_o changes only within a few cycles after a window boundary. It is stable through the middle of a window.
- R10: If the recovered clock stops, the result of a window is never acknowledged. lock_o is then 0 by the next window boundary and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; times the window and registers the flag |
| rec_clk | input | 1 | Recovered high-rate clock under test |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| lock_ref_n | input | 1 | Active-low lock-to-reference control; while low the flag is forced to 0 |
| lock_o | output | 1 | Lock flag, 1 when the last valid window was within tolerance |

## Verification
The bench sweeps the recovered period through both sides of the tolerance edge (197/203 ps against 196/204 ps). A design that compares with the wrong bound or an off-by-one would flip one of these pairs. A period of 40 ps gives 5120 counts, which a wrapping counter would report as exactly nominal and therefore locked. The bench tests the first window after reset and the first window after releasing the reference control, so a design that trusts a partial window raises the flag early. It also stops the recovered clock, which a design without an outstanding-acknowledge check would miss by holding a stale lock. A monitor watches for any flag change in mid-window.

// File: rtl/fld_pkg.sv
`timescale 1ps/1ps
package fld_pkg;

   // Absolute difference between a measured count and its nominal value,
   // compared with a tolerance; all arguments in plain unsigned integers.
   function automatic logic within_tol(input int unsigned cnt,
                                       input int unsigned nom,
                                       input int unsigned tol);
      int unsigned diff;
      diff = (cnt > nom) ? (cnt - nom) : (nom - cnt);
      return (diff <= tol);
   endfunction

   // Width of the saturating window counter: room for four nominal windows.
   function automatic int unsigned count_width(input int unsigned win);
      return $clog2(win) + 2;
   endfunction

endpackage

// File: rtl/fld_sync.sv
`timescale 1ps/1ps
module fld_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fld_rst_sync.sv
`timescale 1ps/1ps
module fld_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fld_divider.sv
`timescale 1ps/1ps
module fld_divider #(
   parameter int unsigned RATIO = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (RATIO == 1) begin : g_bypass
         logic unused_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) unused_q <= 1'b0;
            else        unused_q <= 1'b1;
         end
         assign tick = unused_q;
      end else begin : g_count
         localparam int unsigned PW = $clog2(RATIO);
         localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
         logic [PW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                phase_q <= '0;
            else if (phase_q == LAST)  phase_q <= '0;
            else                       phase_q <= phase_q + 1'b1;
         end
         assign tick = (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/fld_edge_counter.sv
`timescale 1ps/1ps
module fld_edge_counter #(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             req_tgl,
   output logic [CNT_W-1:0] hold_q,
   output logic             ack_tgl_q,
   output logic             win_clr,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic req_s;
   logic req_prev_q;

   fld_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
   );

   assign win_clr = req_s ^ req_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         hold_q     <= '0;
         ack_tgl_q  <= 1'b0;
         req_prev_q <= 1'b0;
      end else begin
         req_prev_q <= req_s;
         if (win_clr) begin
            hold_q    <= cnt_q;
            cnt_q     <= tick ? CNT_W'(1) : '0;
            ack_tgl_q <= ~ack_tgl_q;
         end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fld_window_ctrl.sv
`timescale 1ps/1ps
module fld_window_ctrl #(
   parameter int unsigned WIN_CYCLES  = 1024,
   parameter int unsigned TOL_COUNTS  = 16,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_ref_n,
   input  logic             ack_tgl,
   input  logic [CNT_W-1:0] hold,
   output logic             req_tgl_q,
   output logic             lock_q,
   output logic             ack_evt,
   output logic             lk_sync
);
   import fld_pkg::*;

   localparam int unsigned TW = $clog2(WIN_CYCLES);
   localparam logic [TW-1:0] T_LAST = TW'(WIN_CYCLES - 1);

   logic [TW-1:0] tmr_q;
   logic          ack_s;
   logic          ack_prev_q;
   logic          whole_q;
   logic          win_valid_q;
   logic          boundary;
   logic          outstanding;
   logic          in_tol;

   fld_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
   );
   fld_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_lk_sync (
      .clk(clk), .rst_n(rst_n), .d(lock_ref_n), .q(lk_sync)
   );

   assign boundary    = (tmr_q == T_LAST);
   assign ack_evt     = ack_s ^ ack_prev_q;
   assign outstanding = req_tgl_q ^ ack_s;
   assign in_tol      = within_tol(int'(hold), WIN_CYCLES, TOL_COUNTS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_q <= '0;
      else if (boundary) tmr_q <= '0;
      else tmr_q <= tmr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_prev_q  <= 1'b0;
         req_tgl_q   <= 1'b0;
         lock_q      <= 1'b0;
         whole_q     <= 1'b0;
         win_valid_q <= 1'b0;
      end else begin
         ack_prev_q <= ack_s;
         if (ack_evt) lock_q <= win_valid_q & in_tol;
         if (boundary) begin
            req_tgl_q   <= ~req_tgl_q;
            win_valid_q <= whole_q & lk_sync & ~outstanding;
            whole_q     <= lk_sync;
            if (outstanding) lock_q <= 1'b0;
         end
         if (!lk_sync) begin
            lock_q      <= 1'b0;
            whole_q     <= 1'b0;
            win_valid_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/freq_lock_detect.sv
`timescale 1ps/1ps
module freq_lock_detect #(
   parameter int unsigned DIV_RATIO   = 20,
   parameter int unsigned WIN_CYCLES  = 1024,
   parameter int unsigned TOL_COUNTS  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rec_clk,
   input  logic rst_n,
   input  logic lock_ref_n,
   output logic lock_o
);
   localparam int unsigned CNT_W = fld_pkg::count_width(WIN_CYCLES);

   generate
      if (DIV_RATIO < 1) begin : g_bad_div
         $error("DIV_RATIO must be at least 1");
      end
      if (WIN_CYCLES < 4 || (WIN_CYCLES & (WIN_CYCLES - 1)) != 0) begin : g_bad_win
         $error("WIN_CYCLES must be a power of two of at least 4");
      end
      if (TOL_COUNTS >= WIN_CYCLES) begin : g_bad_tol
         $error("TOL_COUNTS must be below WIN_CYCLES");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             ref_rst_n;
   logic             rec_rst_n;
   logic             tick;
   logic             req_tgl;
   logic             ack_tgl;
   logic [CNT_W-1:0] hold;
   logic [CNT_W-1:0] cnt_q;
   logic             win_clr;
   logic             ack_evt;
   logic             lk_sync;
   logic             lock_q;

   fld_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
      .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
   );
   fld_rst_sync #(.STAGES(SYNC_STAGES)) u_rec_rst (
      .clk(rec_clk), .arst_n(rst_n), .srst_n(rec_rst_n)
   );

   fld_divider #(.RATIO(DIV_RATIO)) u_div (
      .clk(rec_clk), .rst_n(rec_rst_n), .tick(tick)
   );

   fld_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .clk(rec_clk), .rst_n(rec_rst_n), .tick(tick), .req_tgl(req_tgl),
      .hold_q(hold), .ack_tgl_q(ack_tgl), .win_clr(win_clr), .cnt_q(cnt_q)
   );

   fld_window_ctrl #(
      .WIN_CYCLES(WIN_CYCLES), .TOL_COUNTS(TOL_COUNTS),
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_win (
      .clk(ref_clk), .rst_n(ref_rst_n), .lock_ref_n(lock_ref_n),
      .ack_tgl(ack_tgl), .hold(hold), .req_tgl_q(req_tgl),
      .lock_q(lock_q), .ack_evt(ack_evt), .lk_sync(lk_sync)
   );

   assign lock_o = lock_q;
endmodule

// File: rtl/fld_checker.sv
`timescale 1ps/1ps
module fld_checker #(
   parameter int unsigned CNT_W = 12
) (
   input logic             ref_clk,
   input logic             rec_clk,
   input logic             ref_rst_n,
   input logic             rec_rst_n,
   input logic             lock_ref_n,
   input logic             lock_o,
   input logic             ack_evt,
   input logic             lk_sync,
   input logic             win_clr,
   input logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R5: a held-low control forces the flag low
   assert_force_low_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (!lock_ref_n && $past(!lock_ref_n) && $past(!lock_ref_n, 2)) |=> !lock_o);

   // R9: the flag only rises on a returned window result
   assert_rise_on_result_R9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $rose(lock_o) |-> $past(ack_evt));

   // R7: the flag never rises while the control is seen low
   assert_rise_needs_release_R7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $rose(lock_o) |-> $past(lk_sync));

   // R4: a saturated counter stays saturated until the window is cleared
   assert_sat_hold_R4: assert property (@(posedge rec_clk) disable iff (!rec_rst_n)
      (cnt_q == CNT_MAX && !win_clr) |=> (cnt_q == CNT_MAX));

   // R1: the count advances by at most one per recovered cycle
   assert_count_step_R1: assert property (@(posedge rec_clk) disable iff (!rec_rst_n)
      !win_clr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

bind freq_lock_detect fld_checker #(.CNT_W(CNT_W)) u_chk (
   .ref_clk(ref_clk), .rec_clk(rec_clk), .ref_rst_n(ref_rst_n),
   .rec_rst_n(rec_rst_n), .lock_ref_n(lock_ref_n), .lock_o(lock_o),
   .ack_evt(ack_evt), .lk_sync(lk_sync), .win_clr(win_clr), .cnt_q(cnt_q)
);

// File: tb/freq_lock_detect_test.sv
`timescale 1ps/1ps
module freq_lock_detect_test;
   localparam int unsigned WIN   = 1024;
   localparam int unsigned VEC_N = 10;
   // recovered period in ps, expected flag, requirement tag index
   localparam int unsigned VEC_P   [VEC_N] = '{200, 197, 203, 196, 200, 204, 180, 230, 40, 200};
   localparam bit          VEC_EXP [VEC_N] = '{1,   1,   1,   0,   1,   0,   0,   0,   0,  1};

   logic ref_clk = 1'b0;
   logic rec_clk = 1'b0;
   logic rst_n = 1'b0;
   logic lock_ref_n = 1'b1;
   logic lock_o;

   int unsigned rec_period = 200;
   bit rec_run = 1'b1;
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   int mid_changes = 0;
   logic prev_lock = 1'b0;
   bit done = 1'b0;

   freq_lock_detect uut (
      .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
      .lock_ref_n(lock_ref_n), .lock_o(lock_o)
   );

   always #2000 ref_clk = ~ref_clk;

   always begin
      if (rec_run) begin
         #(rec_period / 2) rec_clk = 1'b1;
         #(rec_period - rec_period / 2) rec_clk = 1'b0;
      end else begin
         #1000;
      end
   end

   always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

   // mid-window stability monitor (R9)
   always @(negedge ref_clk) begin
      if (mon_en && rst_n && (cyc % WIN) >= 64 && (cyc % WIN) <= 960 && lock_o !== prev_lock)
         mid_changes++;
      prev_lock <= lock_o;
   end

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: lock_o=%b expected %b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic wait_mid();
      @(negedge ref_clk);
      while ((cyc % WIN) != 512) @(negedge ref_clk);
   endtask

   initial begin
      wait_cycles(10);
      check("R6 reset", lock_o, 1'b0);
      rst_n = 1'b1;
      while (cyc < 1100) @(negedge ref_clk);
      check("R6 first window discarded", lock_o, 1'b0);
      while (cyc < 2200) @(negedge ref_clk);
      check("R6 second window", lock_o, 1'b1);
      mon_en = 1'b1;

      for (int v = 0; v < VEC_N; v++) begin
         rec_period = VEC_P[v];
         wait_cycles(3 * WIN);
         wait_mid();
         if (VEC_P[v] == 40)      check("R4 saturation", lock_o, VEC_EXP[v]);
         else if (VEC_EXP[v])     check("R2 in tolerance", lock_o, VEC_EXP[v]);
         else                     check("R3 out of tolerance", lock_o, VEC_EXP[v]);
      end
      check("R8 relock after drift", lock_o, 1'b1);

      // lock-to-reference control
      mon_en = 1'b0;
      wait_mid();
      lock_ref_n = 1'b0;
      wait_cycles(4);
      check("R5 forced low", lock_o, 1'b0);
      wait_cycles(1500);
      check("R5 held low", lock_o, 1'b0);
      lock_ref_n = 1'b1;
      wait_cycles(1000);
      check("R7 low after release", lock_o, 1'b0);
      wait_cycles(1200);
      check("R7 locks after clean window", lock_o, 1'b1);
      mon_en = 1'b1;

      // stopped recovered clock
      rec_run = 1'b0;
      wait_cycles(3 * WIN);
      check("R10 dead clock", lock_o, 1'b0);
      rec_run = 1'b1;
      rec_period = 200;
      wait_cycles(3 * WIN);
      wait_mid();
      check("R1 nominal division relock", lock_o, 1'b1);

      checks++;
      if (mid_changes != 0) begin
         errors++;
         $display("FAIL R9: mid-window changes=%0d expected 0", mid_changes);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge ref_clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule